// File: doc/BRIEF.md
# Priority interrupt collector with host-raised non-maskable request

This block gathers interrupt causes for a processor core. Seven maskable causes feed it: two external request pins, a drawing-window violation, a display-line match, a bus fault, a single-step event, and a request bit that the host sets in its own control register. Each cause latches into a pending register on its rising edge. An enable register masks the pending bits. The block gives the core one combined maskable request and a code that names the most urgent active cause.

The host can also raise a non-maskable request by setting a second bit in its control register. That request ignores the enable register and takes precedence in the reported code. It stays up until the core acknowledges it. A third host bit tells the core to skip pushing its state when it takes the non-maskable request. This lets the host use the request before the core's stack pointer has been set up.

A small register port reads and writes the enable, pending and host-control registers. The core's stacking and vector fetch sit outside this block.

Top module: `irq_hub`

## Requirements
- R1: After reset the enable, pending and host-control registers read zero, and `irq_req`, `nmi_req`, `nmi_nosave` and `irq_code` are all 0.
- R2: Each pending bit is set by a rising edge of its cause, not by its level. Bit map: 0 window violation, 1 external pin 0, 2 external pin 1, 3 host request, 4 display line, 5 bus fault, 6 single step. A cause that stays high does not set its bit again after the bit has been cleared.
- R3: Writing the pending register (address 1) clears each bit written as 1 and leaves each bit written as 0 unchanged. A rising edge in the same cycle as a clear sets the bit anyway.
- R4: Pending bits are captured whatever the enable register holds. With enable zero, `irq_req` stays 0.
- R5: `irq_req` is 1 exactly when some pending bit has its enable bit (address 0, same bit map) set. It follows register changes without extra delay.
- R6: `irq_code` reports the most urgent enabled pending cause, in this order from most to least urgent: bus fault = 2, external pin 0 = 3, external pin 1 = 4, host request = 5, display line = 6, window = 7, single step = 8. It is 0 when nothing is requested.
- R7: Host-control bit 0 is the host request. Its rising edge, one cycle after the write takes effect, sets pending bit 3.
- R8: A rising edge of host-control bit 1 raises `nmi_req` one cycle after the write takes effect. The enable register does not affect it. While `nmi_req` is 1, `irq_code` is 1.
- R9: `nmi_ack` clears `nmi_req` and host-control bit 1 at the next edge. A host write in the same cycle decides the bit's value instead, and it does not re-raise `nmi_req` unless the bit rises.
- R10: `nmi_nosave` equals host-control bit 2. A 1 tells the core not to push its state when taking the non-maskable request.
- R11: Register map: address 0 enable, address 1 pending, address 2 host control {bit 2 no-save, bit 1 NMI, bit 0 host request}, address 3 reads zero. `reg_rdata` reflects `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 2 | External request pins (bit 0 = pin 0) |
| win_viol | input | 1 | Window violation cause |
| disp_line | input | 1 | Display line reached cause |
| bus_fault | input | 1 | Bus fault cause |
| step_evt | input | 1 | Single-step cause |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| nmi_ack | input | 1 | Core acknowledges the non-maskable request |
| irq_req | output | 1 | Combined maskable request |
| irq_code | output | 4 | Code of the most urgent request |
| nmi_req | output | 1 | Non-maskable request |
| nmi_nosave | output | 1 | Core must skip pushing state |

## Verification
On every cycle the assertions check several rules. A pending bit never appears without a detected edge. A zero enable register blocks the maskable request. The code is 1 whenever the non-maskable request is up, and 0 when nothing is requested. An acknowledge with no coincident edge drops the non-maskable request. Only the bench's scenarios can show the rest: the priority order across all pending and enable combinations, the one-cycle lag of the host-controlled bits, the same-cycle races between set and clear, and between acknowledge and host write, and the edge-only capture of a held cause.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 7;
  localparam int CODE_W = 4;

  // pending / enable bit positions
  localparam int B_WIN  = 0;
  localparam int B_EXT0 = 1;
  localparam int B_EXT1 = 2;
  localparam int B_HOST = 3;
  localparam int B_DISP = 4;
  localparam int B_BUS  = 5;
  localparam int B_STEP = 6;

  // host control bit positions
  localparam int HC_W      = 3;
  localparam int HC_HREQ   = 0;
  localparam int HC_NMI    = 1;
  localparam int HC_NOSAVE = 2;

  localparam logic [CODE_W-1:0] CODE_NONE = 4'd0;
  localparam logic [CODE_W-1:0] CODE_NMI  = 4'd1;
  localparam int CODE_BASE = 2;

  // urgency rank (0 = most urgent) to pending bit index
  function automatic int rank_bit(input int rank);
    case (rank)
      0:       return B_BUS;
      1:       return B_EXT0;
      2:       return B_EXT1;
      3:       return B_HOST;
      4:       return B_DISP;
      5:       return B_WIN;
      default: return B_STEP;
    endcase
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend,
  output logic [N-1:0] set_vec
);
  logic [N-1:0] prev_q, pend_q, pend_d;

  always_comb begin
    set_vec = raw & ~prev_q;
    pend_d  = pend_q;
    if (clr_we) pend_d = pend_d & ~clr_mask;
    pend_d = pend_d | set_vec;           // an edge beats a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= raw;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]      act,
  input  logic              nmi,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    code = CODE_NONE;
    for (int r = N - 1; r >= 0; r--) begin
      if (act[rank_bit(r)]) code = CODE_W'(r + CODE_BASE);
    end
    if (nmi) code = CODE_NMI;
  end
endmodule

// File: rtl/irq_host_ctl.sv
module irq_host_ctl
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [HC_W-1:0] wbits,
  input  logic            ack,
  output logic [HC_W-1:0] ctl,
  output logic            nmi_req,
  output logic            nmi_edge
);
  logic [HC_W-1:0] ctl_q, ctl_d;
  logic            ctl_en;
  logic            prev_q, nmi_q, nmi_d;

  always_comb begin
    ctl_en = wr | ack;
    ctl_d  = ctl_q;
    if (wr)       ctl_d = wbits;         // host write wins over ack
    else if (ack) ctl_d[HC_NMI] = 1'b0;
    nmi_edge = ctl_q[HC_NMI] & ~prev_q;
    nmi_d    = nmi_edge | (nmi_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      prev_q <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      prev_q <= ctl_q[HC_NMI];
      nmi_q  <= nmi_d;
    end
  end

  assign ctl     = ctl_q;
  assign nmi_req = nmi_q;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ext_irq,
  input  logic              win_viol,
  input  logic              disp_line,
  input  logic              bus_fault,
  input  logic              step_evt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              nmi_ack,
  output logic              irq_req,
  output logic [CODE_W-1:0] irq_code,
  output logic              nmi_req,
  output logic              nmi_nosave
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HOST = ADDR_W'(2);

  logic            rst_sync_n;
  logic [NSRC-1:0] raw, pend_q, set_vec, en_q, en_d, active;
  logic            en_wr, pend_wr, host_wr, nmi_edge;
  logic [HC_W-1:0] hctl;
  logic            unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:NSRC];

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  always_comb begin
    raw          = '0;
    raw[B_WIN]   = win_viol;
    raw[B_EXT0]  = ext_irq[0];
    raw[B_EXT1]  = ext_irq[1];
    raw[B_HOST]  = hctl[HC_HREQ];
    raw[B_DISP]  = disp_line;
    raw[B_BUS]   = bus_fault;
    raw[B_STEP]  = step_evt;
    en_wr   = reg_we && (reg_addr == A_EN);
    pend_wr = reg_we && (reg_addr == A_PEND);
    host_wr = reg_we && (reg_addr == A_HOST);
    en_d    = reg_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  en_q <= '0;
    else if (en_wr)   en_q <= en_d;
  end

  irq_edge_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .raw(raw), .clr_we(pend_wr),
    .clr_mask(reg_wdata[NSRC-1:0]), .pend(pend_q), .set_vec(set_vec)
  );

  irq_host_ctl u_host (
    .clk(clk), .rst_n(rst_sync_n), .wr(host_wr), .wbits(reg_wdata[HC_W-1:0]),
    .ack(nmi_ack), .ctl(hctl), .nmi_req(nmi_req), .nmi_edge(nmi_edge)
  );

  assign active = pend_q & en_q;

  irq_prio #(.N(NSRC)) u_prio (.act(active), .nmi(nmi_req), .code(irq_code));

  assign irq_req    = |active;
  assign nmi_nosave = hctl[HC_NOSAVE];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:    reg_rdata[NSRC-1:0] = en_q;
      A_PEND:  reg_rdata[NSRC-1:0] = pend_q;
      A_HOST:  reg_rdata[HC_W-1:0] = hctl;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              irq_req,
  input logic              nmi_req,
  input logic [CODE_W-1:0] irq_code,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   set_vec,
  input logic              nmi_edge,
  input logic              nmi_ack
);
  a_r2_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));

  a_r5_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_req);

  a_r8_nmi_code: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (irq_code == CODE_NMI));

  a_r6_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !nmi_req) |-> (irq_code == CODE_NONE));

  a_r6_req_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_code != CODE_NONE));

  a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !nmi_edge) |=> !nmi_req);
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq_req(irq_req), .nmi_req(nmi_req),
  .irq_code(irq_code), .en_q(en_q), .pend_q(pend_q), .set_vec(set_vec),
  .nmi_edge(nmi_edge), .nmi_ack(nmi_ack)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ext_irq;
  logic        win_viol, disp_line, bus_fault, step_evt;
  logic        reg_we, nmi_ack;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq_req, nmi_req, nmi_nosave;
  logic [3:0]  irq_code;
  int nchk = 0, nbad = 0;
  logic [15:0] rd;

  always #10 clk = ~clk;

  irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .win_viol(win_viol),
    .disp_line(disp_line), .bus_fault(bus_fault), .step_evt(step_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nmi_ack(nmi_ack), .irq_req(irq_req),
    .irq_code(irq_code), .nmi_req(nmi_req), .nmi_nosave(nmi_nosave)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected code from the R6 urgency list
  function automatic int exp_code(input int act);
    int order[7] = '{5, 1, 2, 3, 4, 0, 6};
    for (int r = 0; r < 7; r++)
      if (act[order[r]]) return r + 2;
    return 0;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdreg(input int a, output logic [15:0] d);
    reg_addr = 2'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_pat(input int p);
    @(negedge clk);
    win_viol = p[0]; ext_irq = {p[2], p[1]}; disp_line = p[4];
    bus_fault = p[5]; step_evt = p[6];
    reg_we = p[3]; reg_addr = 2'd2; reg_wdata = 16'h1;
    @(negedge clk);
    win_viol = 0; ext_irq = 0; disp_line = 0; bus_fault = 0; step_evt = 0;
    reg_wdata = 16'h0;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    rst_n = 0; ext_irq = 0; win_viol = 0; disp_line = 0; bus_fault = 0;
    step_evt = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; nmi_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq_req", irq_req, 0);
    chk("R1 nmi_req", nmi_req, 0);
    chk("R1 code", irq_code, 0);
    chk("R1 nosave", nmi_nosave, 0);
    for (int a = 0; a < 3; a++) begin
      rdreg(a, rd); chk("R1 reg", rd, 0);
    end

    // R2/R4/R5/R6 sweep over every pending pattern and enable mask
    for (int p = 0; p < 128; p++) begin
      wr(0, 0);
      wr(1, 16'h7F);
      set_pat(p);
      rdreg(1, rd); chk("R2 pending capture", rd, p);
      chk("R4 no req with enable zero", irq_req, 0);
      for (int e = 0; e < 128; e++) begin
        wr(0, e);
        chk("R5 irq_req", irq_req, ((p & e) != 0) ? 1 : 0);
        chk("R6 code", irq_code, exp_code(p & e));
      end
    end

    // R7 host request lag
    wr(0, 0); wr(1, 16'h7F);
    wr(2, 1);
    rdreg(1, rd); chk("R7 not yet pending", rd[3], 0);
    @(negedge clk);
    rdreg(1, rd); chk("R7 host pending", rd[3], 1);
    wr(2, 0); wr(1, 16'h7F);

    // R2 held level sets once
    @(negedge clk); win_viol = 1;
    @(negedge clk);
    rdreg(1, rd); chk("R2 edge set", rd, 1);
    wr(1, 16'h7F);
    repeat (3) @(negedge clk);
    rdreg(1, rd); chk("R2 held level no reset", rd, 0);
    win_viol = 0; @(negedge clk); win_viol = 1; @(negedge clk);
    rdreg(1, rd); chk("R2 new edge", rd, 1);
    win_viol = 0;

    // R3 partial clear and set-beats-clear
    set_pat(16'h7F);
    wr(1, 16'h05);
    rdreg(1, rd); chk("R3 partial clear", rd, 16'h7A);
    wr(1, 16'h7F);
    @(negedge clk);
    bus_fault = 1; reg_we = 1; reg_addr = 2'd1; reg_wdata = 16'h7F;
    @(negedge clk);
    reg_we = 0; bus_fault = 0;
    rdreg(1, rd); chk("R3 set beats clear", rd, 16'h20);

    // R8 NMI
    wr(0, 16'h7F);
    chk("R6 bus code", irq_code, 2);
    wr(0, 0);
    wr(2, 16'h2);
    chk("R8 nmi lag", nmi_req, 0);
    @(negedge clk);
    chk("R8 nmi raised", nmi_req, 1);
    chk("R8 nmi code", irq_code, 1);
    wr(0, 16'h7F);
    chk("R8 nmi beats maskable", irq_code, 1);
    chk("R5 maskable still up", irq_req, 1);

    // R10 no-save mode
    wr(2, 16'h6);
    chk("R10 nosave", nmi_nosave, 1);
    rdreg(2, rd); chk("R11 host read", rd, 6);

    // R9 acknowledge
    @(negedge clk); nmi_ack = 1;
    @(negedge clk); nmi_ack = 0;
    chk("R9 nmi cleared", nmi_req, 0);
    rdreg(2, rd); chk("R9 nmi bit cleared", rd, 4);
    chk("R9 code back to bus", irq_code, 2);
    wr(2, 16'h2);
    @(negedge clk);
    chk("R9 re-raise", nmi_req, 1);
    @(negedge clk);
    nmi_ack = 1; reg_we = 1; reg_addr = 2'd2; reg_wdata = 16'h2;
    @(negedge clk);
    nmi_ack = 0; reg_we = 0;
    rdreg(2, rd); chk("R9 write wins bit", rd, 2);
    chk("R9 no re-raise", nmi_req, 0);
    chk("R10 nosave follows bit", nmi_nosave, 0);

    // R11 map
    wr(0, 16'h55);
    rdreg(0, rd); chk("R11 enable read", rd, 16'h55);
    rdreg(3, rd); chk("R11 spare zero", rd, 0);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule